// File: doc/BRIEF.md
# Parallel Flash Host Bus Front-End

This block sits between the asynchronous host pins of a parallel NOR flash device and the synchronous logic inside it. The active-low chip-select, write-strobe, output-strobe and pin-reset inputs, and the byte/word mode pin, are oversampled by the core clock through two-flop synchronizers. All edge detection works on the synchronized copies.

Host write cycles are turned into a one-cycle request carrying a byte address and a data word, which a downstream command decoder consumes. The address is taken at the moment the write window opens, which is the later of the two strobe falls. The data is taken when the window closes, which is the earlier of the two strobe rises.

On the read side the block drives a per-bit output enable and the output data. Normal reads return the array word supplied on an input port. When the high-voltage flag on address line 9 is present, reads instead return an identification or sector-group protection code. A low level on the reset pin tri-states the bus, discards any write in flight, and flags an abort if a downstream operation is busy.

Top module: `pflash_front`

## Requirements
- R1: A write is recognised only while chip-select and write-strobe are both low and output-strobe is high. If output-strobe goes low inside the window, the cycle produces no request.
- R2: The request address is sampled when the write window opens, i.e. at the later falling edge of chip-select and write-strobe. Address changes made afterwards are ignored.
- R3: The request data is sampled when the window closes, i.e. at the earlier rising edge of the two strobes. Each cycle yields exactly one single-cycle `wr_valid` pulse.
- R4: While output-strobe is high, all 16 bits of `dq_oe` are 0.
- R5: While chip-select is high, `dq_oe` is 0 whatever output-strobe does.
- R6: In byte mode (`byte_n` low), `dq_oe[15:8]` stays 0 and bit 15 of the data input acts as address bit -1. On writes it becomes `wr_addr[0]` and `wr_data[15:8]` is 0. On normal reads it selects the array high byte (1) or low byte (0) onto bits 7:0. In word mode, `wr_addr[0]` is 0.
- R7: With `hv_a9` high and address bits 1:0 = 00, a read returns 0xAD on bits 7:0.
- R8: With `hv_a9` high and address bits 1:0 = 01, a read returns the device code on bits 7:0: 0x58 when `TOP_BOOT` is 0 and 0xD6 when it is 1. In word mode bits 15:8 return 0x22.
- R9: With `hv_a9` high and address bits 1:0 = 10, a read returns 0x01 on bits 7:0 when `sect_prot` bit [addr top GRP_W bits] is 1, and 0x00 otherwise.
- R10: While the reset pin is low, `dq_oe` is 0, no request is produced, and a write window cut by the reset produces no request.
- R11: A falling edge of the synchronized reset pin while `busy` is high gives a one-cycle `abort` pulse. With `busy` low, no pulse is given.
- R12: A word-mode read without `hv_a9` returns `array_data` on all 16 bits with `dq_oe` all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip-select pin, active low |
| we_n | input | 1 | Write-strobe pin, active low |
| oe_n | input | 1 | Output-strobe pin, active low |
| rp_n | input | 1 | Reset pin, active low |
| byte_n | input | 1 | Low selects byte mode |
| hv_a9 | input | 1 | High-voltage detected on address line 9 |
| addr | input | ADDR_W | Word address pins |
| dq_in | input | 16 | Data pins, input side |
| dq_out | output | 16 | Data pins, output side |
| dq_oe | output | 16 | Per-bit output enable |
| array_data | input | 16 | Word read from the array |
| sect_prot | input | NGRP | Protection status per sector group |
| busy | input | 1 | Downstream operation in progress |
| wr_valid | output | 1 | One-cycle write request strobe |
| wr_addr | output | ADDR_W+1 | Byte address of the request |
| wr_data | output | 16 | Data of the request |
| abort | output | 1 | Operation aborted by the reset pin |

## Verification
The assertions assume that the host holds every pin level for at least three clock cycles, so that each change survives both synchronizer stages. They also assume that address, data, `hv_a9` and `sect_prot` stay stable around each strobe edge, since those inputs are sampled without synchronization. The stimulus drives every pin on the falling clock edge and waits several cycles after each change. Address and data updates are spaced well away from the strobe edges that should ignore them.

// File: rtl/pf_pkg.sv
package pf_pkg;
  localparam int DQ_W = 16;
  localparam logic [7:0] MFR_CODE    = 8'hAD;
  localparam logic [7:0] DEV_BOTTOM  = 8'h58;
  localparam logic [7:0] DEV_TOP     = 8'hD6;
  localparam logic [7:0] DEV_UPPER   = 8'h22;
  typedef enum logic [1:0] {
    ID_MFR  = 2'b00,
    ID_DEV  = 2'b01,
    ID_PROT = 2'b10,
    ID_NONE = 2'b11
  } id_sel_e;
endpackage

// File: rtl/pf_sync.sv
module pf_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/pf_wr_capture.sv
module pf_wr_capture #(
  parameter int ADDR_W = 19
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ce_s,
  input  logic                 we_s,
  input  logic                 oe_s,
  input  logic                 rp_s,
  input  logic                 byte_md,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [pf_pkg::DQ_W-1:0] dq_in,
  output logic                 wr_valid,
  output logic [ADDR_W:0]      wr_addr,
  output logic [pf_pkg::DQ_W-1:0] wr_data
);
  localparam int HB = pf_pkg::DQ_W / 2;
  logic win, win_q, byte_q;

  assign win = ~ce_s & ~we_s & oe_s & rp_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q    <= 1'b0;
      byte_q   <= 1'b0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      win_q    <= win;
      wr_valid <= 1'b0;
      if (win && !win_q) begin
        byte_q  <= byte_md;
        wr_addr <= byte_md ? {addr, dq_in[pf_pkg::DQ_W-1]} : {addr, 1'b0};
      end
      if (!win && win_q && rp_s && oe_s) begin
        wr_valid <= 1'b1;
        wr_data  <= byte_q ? {{HB{1'b0}}, dq_in[HB-1:0]} : dq_in;
      end
    end
  end
endmodule

// File: rtl/pf_rd_path.sv
module pf_rd_path
  import pf_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int NGRP     = 8,
  parameter bit TOP_BOOT = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_s,
  input  logic              we_s,
  input  logic              oe_s,
  input  logic              rp_s,
  input  logic              byte_md,
  input  logic              hv_a9,
  input  logic [ADDR_W-1:0] addr,
  input  logic              a_m1,
  input  logic [DQ_W-1:0]   array_data,
  input  logic [NGRP-1:0]   sect_prot,
  output logic [DQ_W-1:0]   dq_out,
  output logic [DQ_W-1:0]   dq_oe
);
  localparam int HB    = DQ_W / 2;
  localparam int GRP_W = (NGRP > 1) ? $clog2(NGRP) : 1;
  localparam logic [7:0] DEV_CODE = TOP_BOOT ? DEV_TOP : DEV_BOTTOM;

  logic            rd;
  logic [GRP_W-1:0] grp;
  logic [DQ_W-1:0] nxt;
  id_sel_e         sel;

  assign rd  = ~ce_s & ~oe_s & we_s & rp_s;
  assign grp = addr[ADDR_W-1 -: GRP_W];
  assign sel = id_sel_e'(addr[1:0]);

  always_comb begin
    nxt = '0;
    if (hv_a9) begin
      case (sel)
        ID_MFR:  nxt[HB-1:0] = MFR_CODE;
        ID_DEV:  nxt = {byte_md ? 8'h00 : DEV_UPPER, DEV_CODE};
        ID_PROT: nxt[0] = (32'(grp) < NGRP) ? sect_prot[grp] : 1'b0;
        default: nxt = '0;
      endcase
    end else if (byte_md) begin
      nxt[HB-1:0] = a_m1 ? array_data[DQ_W-1:HB] : array_data[HB-1:0];
    end else begin
      nxt = array_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_out <= '0;
      dq_oe  <= '0;
    end else begin
      dq_out <= rd ? nxt : '0;
      dq_oe  <= {{HB{rd & ~byte_md}}, {HB{rd}}};
    end
  end
endmodule

// File: rtl/pflash_front.sv
module pflash_front
  import pf_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int NGRP     = 8,
  parameter bit TOP_BOOT = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              rp_n,
  input  logic              byte_n,
  input  logic              hv_a9,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       dq_in,
  output logic [15:0]       dq_out,
  output logic [15:0]       dq_oe,
  input  logic [15:0]       array_data,
  input  logic [NGRP-1:0]   sect_prot,
  input  logic              busy,
  output logic              wr_valid,
  output logic [ADDR_W:0]   wr_addr,
  output logic [15:0]       wr_data,
  output logic              abort
);
  localparam int NSYNC = 5;
  logic [NSYNC-1:0] pins_s;
  logic ce_s, we_s, oe_s, rp_s, byte_md, rp_q;

  pf_sync #(.W(NSYNC), .RST_VAL({NSYNC{1'b1}})) u_sync (
    .clk(clk), .rst(rst),
    .d({byte_n, rp_n, oe_n, we_n, ce_n}),
    .q(pins_s)
  );

  assign ce_s    = pins_s[0];
  assign we_s    = pins_s[1];
  assign oe_s    = pins_s[2];
  assign rp_s    = pins_s[3];
  assign byte_md = ~pins_s[4];

  pf_wr_capture #(.ADDR_W(ADDR_W)) u_wr (
    .clk(clk), .rst(rst),
    .ce_s(ce_s), .we_s(we_s), .oe_s(oe_s), .rp_s(rp_s), .byte_md(byte_md),
    .addr(addr), .dq_in(dq_in),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  pf_rd_path #(.ADDR_W(ADDR_W), .NGRP(NGRP), .TOP_BOOT(TOP_BOOT)) u_rd (
    .clk(clk), .rst(rst),
    .ce_s(ce_s), .we_s(we_s), .oe_s(oe_s), .rp_s(rp_s), .byte_md(byte_md),
    .hv_a9(hv_a9), .addr(addr), .a_m1(dq_in[15]),
    .array_data(array_data), .sect_prot(sect_prot),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rp_q  <= 1'b1;
      abort <= 1'b0;
    end else begin
      rp_q  <= rp_s;
      abort <= rp_q & ~rp_s & busy;
    end
  end
endmodule

// File: rtl/pflash_front_chk.sv
module pflash_front_chk (
  input logic        clk,
  input logic        rst,
  input logic        ce_s,
  input logic        oe_s,
  input logic        rp_s,
  input logic        byte_md,
  input logic        busy,
  input logic [15:0] dq_oe,
  input logic        wr_valid,
  input logic        abort
);
  // R4
  oe_high_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    oe_s |=> (dq_oe == 16'h0));
  // R5
  standby_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ce_s |=> (dq_oe == 16'h0));
  // R6
  byte_upper_off_chk: assert property (@(posedge clk) disable iff (rst)
    (|dq_oe[15:8]) |-> $past(!byte_md));
  // R10
  pin_reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rp_s |=> (dq_oe == 16'h0) && !wr_valid);
  // R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> !wr_valid);
  // R11
  abort_busy_chk: assert property (@(posedge clk) disable iff (rst)
    abort |-> $past(busy));
  // R11
  abort_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    abort |=> !abort);
endmodule

bind pflash_front pflash_front_chk u_chk (
  .clk(clk), .rst(rst), .ce_s(ce_s), .oe_s(oe_s), .rp_s(rp_s),
  .byte_md(byte_md), .busy(busy), .dq_oe(dq_oe),
  .wr_valid(wr_valid), .abort(abort)
);

// File: tb/pflash_front_test.sv
module pflash_front_test;
  localparam int AW = 19;
  localparam int NG = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, rp_n = 1'b1, byte_n = 1'b1;
  logic hv_a9 = 1'b0, busy = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0] dq_in = '0, array_data = '0;
  logic [NG-1:0] sect_prot = '0;
  logic [15:0] dq_out, dq_oe, wr_data;
  logic [AW:0] wr_addr;
  logic wr_valid, abort;

  int total = 0, bad = 0, npulse = 0, nabort = 0;
  logic [AW:0] last_addr;
  logic [15:0] last_data;
  bit done = 0;

  always #5 clk = ~clk;

  pflash_front uut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .rp_n(rp_n),
    .byte_n(byte_n), .hv_a9(hv_a9), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .array_data(array_data),
    .sect_prot(sect_prot), .busy(busy), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .abort(abort)
  );

  always @(posedge clk) begin
    if (wr_valid) begin
      npulse    <= npulse + 1;
      last_addr <= wr_addr;
      last_data <= wr_data;
    end
    if (abort) nabort <= nabort + 1;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    ce_n = 1; we_n = 1; oe_n = 1; hv_a9 = 0;
    settle();
  endtask

  task automatic t_reset_state();
    check(dq_oe == 0, "R4 reset", dq_oe, 0);
    check(npulse == 0, "R3 reset", npulse, 0);
  endtask

  task automatic t_word_write();
    int p0 = npulse;
    byte_n = 1; addr = 19'h1111; ce_n = 0; settle();
    addr = 19'h2A5A5; we_n = 0; settle();
    addr = 19'h33333; dq_in = 16'hBEEF; settle();
    we_n = 1; settle();
    dq_in = 16'h0000; ce_n = 1; settle();
    check(npulse == p0 + 1, "R3 count", npulse - p0, 1);
    check(last_addr == {19'h2A5A5, 1'b0}, "R2 later fall", last_addr, {19'h2A5A5, 1'b0});
    check(last_data == 16'hBEEF, "R3 earlier rise", last_data, 16'hBEEF);
  endtask

  task automatic t_oe_abort_write();
    int p0 = npulse;
    oe_n = 1; ce_n = 0; we_n = 0; settle();
    oe_n = 0; settle();
    we_n = 1; ce_n = 1; settle();
    oe_n = 1; settle();
    check(npulse == p0, "R1 oe low", npulse - p0, 0);
  endtask

  task automatic t_byte_write();
    int p0 = npulse;
    byte_n = 0; settle();
    addr = 19'h00123; dq_in = 16'h8077; we_n = 0; settle();
    ce_n = 0; settle();
    ce_n = 1; settle();
    we_n = 1; settle();
    check(npulse == p0 + 1, "R6 byte write count", npulse - p0, 1);
    check(last_addr == {19'h00123, 1'b1}, "R6 byte addr", last_addr, {19'h00123, 1'b1});
    check(last_data == 16'h0077, "R6 byte data", last_data, 16'h0077);
    byte_n = 1; dq_in = 0; settle();
  endtask

  task automatic t_tristate();
    ce_n = 0; oe_n = 1; settle();
    check(dq_oe == 0, "R4 oe high", dq_oe, 0);
    ce_n = 1; oe_n = 0; settle();
    check(dq_oe == 0, "R5 standby", dq_oe, 0);
    idle();
  endtask

  task automatic t_array_read();
    array_data = 16'hC3A1; addr = 19'h00040; byte_n = 1;
    ce_n = 0; oe_n = 0; settle();
    check(dq_oe == 16'hFFFF, "R12 oe", dq_oe, 16'hFFFF);
    check(dq_out == 16'hC3A1, "R12 data", dq_out, 16'hC3A1);
    byte_n = 0; dq_in = 16'h8000; settle();
    check(dq_oe == 16'h00FF, "R6 byte oe", dq_oe, 16'h00FF);
    check(dq_out[7:0] == 8'hC3, "R6 high byte", dq_out[7:0], 8'hC3);
    dq_in = 16'h0000; settle();
    check(dq_out[7:0] == 8'hA1, "R6 low byte", dq_out[7:0], 8'hA1);
    byte_n = 1; idle();
  endtask

  task automatic t_id_read();
    sect_prot = 8'b0010_0100; hv_a9 = 1; byte_n = 1;
    addr = 19'h00000; ce_n = 0; oe_n = 0; settle();
    check(dq_out[7:0] == 8'hAD, "R7 mfr", dq_out[7:0], 8'hAD);
    addr = 19'h00001; settle();
    check(dq_out == 16'h2258, "R8 dev word", dq_out, 16'h2258);
    byte_n = 0; settle();
    check(dq_out[7:0] == 8'h58, "R8 dev byte", dq_out[7:0], 8'h58);
    byte_n = 1;
    addr = {3'd2, 16'h0002}; settle();
    check(dq_out[7:0] == 8'h01, "R9 protected", dq_out[7:0], 8'h01);
    addr = {3'd3, 16'h0002}; settle();
    check(dq_out[7:0] == 8'h00, "R9 unprotected", dq_out[7:0], 8'h00);
    idle();
  endtask

  task automatic t_pin_reset();
    int p0 = npulse;
    int a0 = nabort;
    busy = 0; rp_n = 0; settle();
    check(nabort == a0, "R11 idle no abort", nabort - a0, 0);
    ce_n = 0; oe_n = 0; settle();
    check(dq_oe == 0, "R10 read blocked", dq_oe, 0);
    oe_n = 1; we_n = 0; settle();
    we_n = 1; settle();
    check(npulse == p0, "R10 write blocked", npulse - p0, 0);
    rp_n = 1; ce_n = 1; settle();
    ce_n = 0; we_n = 0; settle();
    busy = 1; rp_n = 0; settle();
    check(nabort == a0 + 1, "R11 abort", nabort - a0, 1);
    we_n = 1; ce_n = 1; settle();
    check(npulse == p0, "R10 cut write", npulse - p0, 0);
    busy = 0; rp_n = 1; settle();
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0;
    settle();
    t_reset_state();
    t_word_write();
    t_oe_abort_write();
    t_byte_write();
    t_tristate();
    t_array_read();
    t_id_read();
    t_pin_reset();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule